// File: doc/BRIEF.md
# Multiprocessor Periodic Timer Unit

A bank of periodic interval timers for a multiprocessor system. Every processor owns one private timer, and one further master timer is shared by all of them. Each timer counts down from a programmed limit, one step per pulse on a common tick-enable input. When it reaches the end of its interval it sets a sticky limit-reached flag, reloads itself and keeps running, so every period has the same length. Each private flag drives a level-14 request to its own processor only. The master flag drives a level-10 request that goes to every processor at once.

Software reaches the timers through a word-wide register bus with one-cycle read latency. Each timer occupies four consecutive words. The first word holds the limit and the flag: reading it returns both values and acknowledges the flag. The second word shows the running count. The third word loads a new limit and leaves a pending flag untouched. The fourth word is the enable control. The limit field sits at bits 30:10 of the limit and count words, and the flag sits at bit 31. At reset the limit word is 0x009C4000, which is 10000 ticks, or 10 ms with a 1 MHz tick.

Top module: `ptimer_bank`

## Requirements
- R1: After reset every limit word and every count word reads 0x009C4000, every control word reads 0, and all interrupt outputs are low.
- R2: After bit 0 of the control word (offset 3) is written as 1, the flag (bit 31) and the timer's interrupt output rise after exactly L tick_i cycles, where L is the limit field (bits 30:10). The timer then reloads and flags again every L ticks. The default L is 10000.
- R3: A timer counts only in cycles where it is enabled and tick_i is high. Writing control bit 0 as 0 freezes the count. A count word (offset 1) reads as {flag, count, 10'b0}.
- R4: A read of the limit word (offset 0) returns {flag, limit, 10'b0}. That read clears the flag, so the interrupt output is low from the next cycle.
- R5: A write to the limit word loads bits 30:10 as the new limit, restarts the count from that value and clears the flag. Bits 31 and 9:0 of the written data are discarded.
- R6: A write to the no-clear word (offset 2) loads the limit and restarts the count but leaves the flag unchanged. Reads of offset 2 return 0.
- R7: Private timer i drives only irq14_o[i]. The master timer (index NUM_CPU) drives every bit of irq10_o.
- R8: Word address = timer index * 4 + offset. Reads of words at or above 4*(NUM_CPU+1) return 0, and writes to them have no effect.
- R9: For a read request, rdata_o carries the result and rvalid_o is high in the cycle after the request. rvalid_o is low after any other cycle.
- R10: If a timer reaches terminal in the same cycle that its limit word is read, the read returns the old flag and the flag ends up set.
- R11: A limit field of 0 or 1 gives a period of one tick.
- R12: Writes to a count word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W = clog2(4*(NUM_CPU+1)) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| irq14_o | output | NUM_CPU | Private timer requests, one per processor |
| irq10_o | output | NUM_CPU | Master timer request, copied to every processor |

## Verification
The bench builds the default of NUM_CPU = 4 and keeps the reset limit. This configuration gives five timers in a five-bit address space, so words 20 to 31 exist but are unmapped and their read-as-zero behaviour can be tested. The full 10000-tick default period also runs in a short test. With four private lines, the bench can show that one timer's flag stays off its neighbours' lines and that the master request reaches every processor. A read issued in the same cycle as a tick makes the set-versus-acknowledge collision reachable.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int FLAG_BIT = 31;
  localparam int CNT_LSB  = 10;
  localparam int LIM_W    = FLAG_BIT - CNT_LSB;
  localparam logic [31:0] DEF_LIMIT_WORD = 32'h009C_4000;

  typedef enum logic [1:0] {
    OFF_LIMIT = 2'd0,
    OFF_COUNT = 2'd1,
    OFF_NOCLR = 2'd2,
    OFF_CTRL  = 2'd3
  } reg_off_e;
endpackage

// File: rtl/ptimer_dec.sv
module ptimer_dec
  import ptimer_pkg::*;
#(
  parameter int NUM_T  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_T-1:0]  wr_o,
  output logic [NUM_T-1:0]  rd_o,
  output reg_off_e          off_o
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] tsel;
  assign tsel  = addr_i[ADDR_W-1:2];
  assign off_o = reg_off_e'(addr_i[1:0]);

  for (genvar i = 0; i < NUM_T; i++) begin : g_sel
    logic hit;
    assign hit   = req_i && (tsel == SEL_W'(i));
    assign wr_o[i] = hit && we_i;
    assign rd_o[i] = hit && !we_i;
  end
endmodule

// File: rtl/ptimer_unit.sv
module ptimer_unit
  import ptimer_pkg::*;
#(
  parameter logic [31:0] RST_WORD = DEF_LIMIT_WORD
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  reg_off_e    off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        flag_o
);
  localparam logic [LIM_W-1:0] RST_LIM = RST_WORD[FLAG_BIT-1:CNT_LSB];

  logic [LIM_W-1:0] lim_q, cnt_q, wfield;
  logic             en_q, flag_q;
  logic             wr_lim, wr_ncl, wr_ctl, rd_lim, run, term;
  logic             unused_wbits;

  assign wfield       = wdata_i[FLAG_BIT-1:CNT_LSB];
  assign unused_wbits = ^{wdata_i[31], wdata_i[9:1]};
  assign wr_lim = wr_i && (off_i == OFF_LIMIT);
  assign wr_ncl = wr_i && (off_i == OFF_NOCLR);
  assign wr_ctl = wr_i && (off_i == OFF_CTRL);
  assign rd_lim = rd_i && (off_i == OFF_LIMIT);
  assign run    = en_q && tick_i;
  // limit 0 or 1 both give a one-tick period
  assign term   = run && (cnt_q <= LIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= RST_LIM;
      cnt_q  <= RST_LIM;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_lim || wr_ncl) lim_q <= wfield;
      if (wr_ctl) en_q <= wdata_i[0];

      if (wr_lim || wr_ncl)                cnt_q <= wfield;
      else if (wr_ctl && wdata_i[0] && !en_q) cnt_q <= lim_q;
      else if (term)                       cnt_q <= lim_q;
      else if (run)                        cnt_q <= cnt_q - LIM_W'(1);

      // clearing write beats terminal; terminal beats read-acknowledge
      if (wr_lim)      flag_q <= 1'b0;
      else if (term)   flag_q <= 1'b1;
      else if (rd_lim) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_LIMIT: rdata_o = {flag_q, lim_q, {CNT_LSB{1'b0}}};
      OFF_COUNT: rdata_o = {flag_q, cnt_q, {CNT_LSB{1'b0}}};
      OFF_NOCLR: rdata_o = '0;
      default:   rdata_o = {31'd0, en_q};
    endcase
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank
  import ptimer_pkg::*;
#(
  parameter int          NUM_CPU   = 4,
  parameter logic [31:0] DEF_LIMIT = DEF_LIMIT_WORD,
  localparam int         NUM_T     = NUM_CPU + 1,
  localparam int         ADDR_W    = $clog2(NUM_T * 4)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               rvalid_o,
  output logic [NUM_CPU-1:0] irq14_o,
  output logic [NUM_CPU-1:0] irq10_o
);
  logic [NUM_T-1:0] wr_sel, rd_sel, flag;
  logic [31:0]      tdata [NUM_T];
  logic [31:0]      rd_mux;
  reg_off_e         off;

  ptimer_dec #(.NUM_T(NUM_T), .ADDR_W(ADDR_W)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .wr_o  (wr_sel),
    .rd_o  (rd_sel),
    .off_o (off)
  );

  for (genvar i = 0; i < NUM_T; i++) begin : g_tmr
    ptimer_unit #(.RST_WORD(DEF_LIMIT)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .wr_i   (wr_sel[i]),
      .rd_i   (rd_sel[i]),
      .off_i  (off),
      .wdata_i(wdata_i),
      .rdata_o(tdata[i]),
      .flag_o (flag[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_T; i++) begin
      if (rd_sel[i]) rd_mux = rd_mux | tdata[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      rdata_o  <= (req_i && !we_i) ? rd_mux : '0;
    end
  end

  assign irq14_o = flag[NUM_CPU-1:0];
  assign irq10_o = {NUM_CPU{flag[NUM_CPU]}};
endmodule

// File: rtl/ptimer_bank_chk.sv
module ptimer_bank_chk #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        rdata_o,
  input logic               rvalid_o,
  input logic [NUM_CPU-1:0] irq14_o,
  input logic [NUM_CPU-1:0] irq10_o
);
  localparam int NWORDS = 4 * (NUM_CPU + 1);

  a_r9_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r9_rvalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && ($past(32'(addr_i)) >= 32'(NWORDS))) |-> (rdata_o == '0));
  a_r6_alias_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && ($past(addr_i[1:0]) == 2'd2)) |-> (rdata_o == '0));
  a_r3_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[9:1] == '0));
  a_r2_master_set_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq10_o[0]) |-> $past(tick_i));

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    a_r2_set_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq14_o[i]) |-> $past(tick_i));
    a_r4_clear_by_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq14_o[i]) |-> $past(req_i));
  end
endmodule

bind ptimer_bank ptimer_bank_chk #(.NUM_CPU(NUM_CPU), .ADDR_W($clog2(4 * (NUM_CPU + 1)))) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .rvalid_o(rvalid_o),
  .irq14_o (irq14_o),
  .irq10_o (irq10_o)
);

// File: tb/ptimer_bank_tb.sv
module ptimer_bank_tb;
  localparam int NCPU = 4;
  localparam int AW   = 5;
  localparam int MST  = NCPU * 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tick_i = 1'b0;
  logic            req_i = 1'b0;
  logic            we_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic            rvalid_o;
  logic [NCPU-1:0] irq14_o, irq10_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  ptimer_bank #(.NUM_CPU(NCPU)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(a);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  function automatic logic [31:0] lw(input int l);
    return 32'(l) << 10;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);       chk("R1 limit t0", d, 32'h009C4000);
    rd(MST, d);     chk("R1 limit master", d, 32'h009C4000);
    rd(4 + 1, d);   chk("R1 count t1", d, 32'h009C4000);
    rd(8 + 3, d);   chk("R1 ctrl t2", d, 32'h0);
    chk("R1 irq14", 32'(irq14_o), 32'h0);
    chk("R1 irq10", 32'(irq10_o), 32'h0);
  endtask

  task automatic t_rvalid();
    logic [31:0] d;
    rd(0, d);
    chk("R9 rvalid after read", 32'(rvalid_o), 32'h1);
    @(negedge clk_i);
    chk("R9 rvalid idle", 32'(rvalid_o), 32'h0);
  endtask

  task automatic t_default_period();
    logic [31:0] d;
    wr(8 + 3, 32'h1);
    ticks(9999);
    chk("R2 default not yet", 32'(irq14_o[2]), 32'h0);
    ticks(1);
    chk("R2 default 10000 ticks", 32'(irq14_o), 32'h4);
    rd(8, d);       chk("R4 read flag+limit", d, 32'h809C4000);
    chk("R4 read clears irq", 32'(irq14_o[2]), 32'h0);
    wr(8 + 3, 32'h0);
  endtask

  task automatic t_period_count();
    logic [31:0] d;
    wr(0, lw(5));
    wr(3, 32'h1);
    ticks(4);
    chk("R2 L=5 after 4", 32'(irq14_o), 32'h0);
    ticks(1);
    chk("R2 L=5 after 5, R7 own line only", 32'(irq14_o), 32'h1);
    chk("R7 master quiet", 32'(irq10_o), 32'h0);
    rd(0, d);       chk("R4 limit read", d, 32'h80001400);
    chk("R4 cleared", 32'(irq14_o[0]), 32'h0);
    ticks(4);
    chk("R2 reload not yet", 32'(irq14_o[0]), 32'h0);
    ticks(1);
    chk("R2 reload period", 32'(irq14_o[0]), 32'h1);
    rd(0, d);
    ticks(2);
    rd(1, d);       chk("R3 count read", d, lw(3));
    wr(3, 32'h0);
    ticks(10);
    rd(1, d);       chk("R3 frozen when disabled", d, lw(3));
    rd(3, d);       chk("R3 ctrl reads 0", d, 32'h0);
  endtask

  task automatic t_noclear();
    logic [31:0] d;
    wr(4, lw(3));
    wr(4 + 3, 32'h1);
    ticks(3);
    chk("R2 t1 flag", 32'(irq14_o), 32'h2);
    wr(4 + 2, lw(7));
    chk("R6 noclear keeps irq", 32'(irq14_o[1]), 32'h1);
    rd(4 + 2, d);   chk("R6 alias reads 0", d, 32'h0);
    rd(4 + 1, d);   chk("R6 count restarted, flag kept", d, 32'h80001C00);
    rd(4, d);       chk("R6 new limit", d, 32'h80001C00);
    ticks(6);
    chk("R6 new period not yet", 32'(irq14_o[1]), 32'h0);
    ticks(1);
    chk("R6 new period", 32'(irq14_o[1]), 32'h1);
    wr(4, 32'hFFFF_FFFF);
    chk("R5 write clears irq", 32'(irq14_o[1]), 32'h0);
    rd(4, d);       chk("R5 field only", d, 32'h7FFFFC00);
    wr(4 + 3, 32'h0);
  endtask

  task automatic t_master();
    logic [31:0] d;
    wr(MST, lw(2));
    wr(MST + 3, 32'h1);
    ticks(2);
    chk("R7 master all cpus", 32'(irq10_o), 32'hF);
    chk("R7 private untouched", 32'(irq14_o), 32'h0);
    rd(MST, d);     chk("R4 master read", d, 32'h80000800);
    chk("R4 master cleared", 32'(irq10_o), 32'h0);
    wr(MST + 3, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(20, 32'hFFFF_FFFF);
    rd(20, d);      chk("R8 word 20", d, 32'h0);
    rd(31, d);      chk("R8 word 31", d, 32'h0);
    rd(0, d);       chk("R8 t0 untouched", d, lw(5));
    chk("R8 no irq", 32'(irq14_o | irq10_o), 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(8, lw(1));
    wr(8 + 3, 32'h1);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(8); tick_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; tick_i = 1'b0;
    d = rdata_o;
    chk("R10 read old flag", d, lw(1));
    chk("R10 flag stays set", 32'(irq14_o[2]), 32'h1);
    rd(8, d);
    ticks(1);
    chk("R11 limit 1 one tick", 32'(irq14_o[2]), 32'h1);
    wr(8 + 3, 32'h0);
  endtask

  task automatic t_zero_and_count_write();
    logic [31:0] d;
    wr(12, 32'h0);
    wr(12 + 3, 32'h1);
    ticks(1);
    chk("R11 limit 0 one tick", 32'(irq14_o[3]), 32'h1);
    wr(12 + 3, 32'h0);
    wr(12 + 1, 32'h1234_5678);
    rd(12 + 1, d);  chk("R12 count write ignored", d, 32'h80000000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_rvalid();
    t_default_period();
    t_period_count();
    t_noclear();
    t_master();
    t_unmapped();
    t_collision();
    t_zero_and_count_write();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule